// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries out the hidden call into an interrupt handler for a core with 16-bit addressing. When a granted 8-bit vector arrives, the block captures the current code segment, instruction pointer, flags and stack pointer. It writes a three-word frame below the stack pointer and reads a 4-byte entry from the handler table. It then presents the new code segment, instruction pointer, stack pointer and the entry-adjusted flags. A separate return command undoes this work. It reads the three frame words back in the reverse of the order they were written and presents the restored state.

All memory traffic goes through one 16-bit request/ready port that uses byte addresses. Each access holds its request until `mem_rdy` is high at a clock edge, and the sequencer only moves to the next step after that edge. The block asserts `busy` from the edge where it accepts a command until the edge where it loads its results. The `done` pulse marks the single cycle in which the result outputs first carry the new state.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all low.
- R2: The handler offset is read as a word at byte address `tbl_base + 4*vector`, and the selector at that address plus 2. Both sums wrap modulo 2^16.
- R3: On entry, with S the captured stack pointer, the block writes the code segment at S-2, then the instruction pointer at S-4, then the low 16 bits of the flags at S-6, in that order.
- R4: The entry flags result equals the captured flags with bits 8 (trap), 9 (interrupt enable), 16 (resume) and 18 (alignment check) cleared. All other bits are unchanged.
- R5: After entry, `new_cs` is the selector read from the table, `new_ip` is the offset read from the table, and `new_sp` is S-6.
- R6: On return, with S the captured stack pointer, the block reads the flags word at S, the instruction pointer at S+2 and the code segment at S+4. It then presents them with `new_sp` = S+6. The upper 16 bits of `new_flags` are taken from `cur_flags`.
- R7: `busy` rises on the edge that accepts a command and falls on the edge that loads the results. `done` is high for exactly that one following cycle, with `busy` low.
- R8: `vec_valid` and `ret_req` are ignored while `busy` is high. No second sequence starts and the results belong to the accepted command.
- R9: A request's address, write enable and data stay stable until `mem_rdy` is high. With W wait cycles per access, `done` appears 5(W+1) edges after an entry is accepted and 3(W+1) edges after a return is accepted.
- R10: When `vec_valid` and `ret_req` are both high while idle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | Granted vector present |
| vec_num | input | 8 | Vector number |
| ret_req | input | 1 | Return-from-handler command |
| tbl_base | input | 16 | Byte address of the handler table |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_flags | input | 32 | Current flags |
| cur_sp | input | 16 | Current stack pointer (byte address) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when results are loaded |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| new_flags | output | 32 | Resulting flags |
| new_sp | output | 16 | Resulting stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | Access completes at this edge |

## Verification
Most internal faults surface at the ports within one command. A stack pointer stepping the wrong way or by the wrong amount puts frame words at the wrong addresses, and the returned `new_sp` is off. A mis-sequenced state machine either swaps the words in the frame or changes the count of accesses. That shows as a wrong `done` latency for that same command. A bad flag mask or table address computation is visible in `new_flags`, `new_ip` or `new_cs` the cycle `done` rises. A fault that lets a command start while busy shows up as an extra `done` pulse or a corrupted frame before the next command.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_PUSH_FL,
    ST_RD_OFS,
    ST_RD_SEL,
    ST_POP_FL,
    ST_POP_IP,
    ST_POP_CS
  } seq_state_t;

  // flag bit positions cleared on handler entry
  localparam int FLAG_TF_BIT = 8;
  localparam int FLAG_IF_BIT = 9;
  localparam int FLAG_RF_BIT = 16;
  localparam int FLAG_AC_BIT = 18;

  function automatic logic is_push(input seq_state_t s);
    return (s == ST_PUSH_CS) || (s == ST_PUSH_IP) || (s == ST_PUSH_FL);
  endfunction

  function automatic logic is_pop(input seq_state_t s);
    return (s == ST_POP_FL) || (s == ST_POP_IP) || (s == ST_POP_CS);
  endfunction

endpackage

// File: rtl/int_seq_addr_gen.sv
module int_seq_addr_gen
  import int_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int VEC_W = 8
) (
  input  seq_state_t        state_n,
  input  logic [AW-1:0]     sp_n,
  input  logic [AW-1:0]     base_n,
  input  logic [VEC_W-1:0]  vec_n,
  input  logic [DW-1:0]     cs_n,
  input  logic [DW-1:0]     ip_n,
  input  logic [DW-1:0]     fl_n,
  output logic [AW-1:0]     addr,
  output logic              we,
  output logic [DW-1:0]     wdata,
  output logic              active
);
  localparam int WORD_BYTES  = DW / 8;
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] entry_addr;
  assign entry_addr = base_n + (AW'(vec_n) << ENTRY_SHIFT);

  always_comb begin
    addr   = '0;
    we     = 1'b0;
    wdata  = '0;
    active = 1'b1;
    unique case (state_n)
      ST_PUSH_CS: begin addr = sp_n - STEP; we = 1'b1; wdata = cs_n; end
      ST_PUSH_IP: begin addr = sp_n - STEP; we = 1'b1; wdata = ip_n; end
      ST_PUSH_FL: begin addr = sp_n - STEP; we = 1'b1; wdata = fl_n; end
      ST_RD_OFS:  addr = entry_addr;
      ST_RD_SEL:  addr = entry_addr + STEP;
      ST_POP_FL, ST_POP_IP, ST_POP_CS: addr = sp_n;
      default:    active = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_seq_mem_port.sv
module int_seq_mem_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          active,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_req   <= active;
      mem_we    <= we;
      mem_addr  <= addr;
      mem_wdata <= wdata;
    end
  end
endmodule

// File: rtl/int_seq_result.sv
module int_seq_result
  import int_seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_entry,
  input  logic              fin_ret,
  input  logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     ofs_q,
  input  logic [DW-1:0]     popfl_q,
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [AW-1:0]     sp_n,
  output logic              done,
  output logic [DW-1:0]     new_cs,
  output logic [DW-1:0]     new_ip,
  output logic [FLAG_W-1:0] new_flags,
  output logic [AW-1:0]     new_sp
);
  localparam logic [FLAG_W-1:0] CLR_MASK = FLAG_W'((64'd1 << FLAG_TF_BIT) |
                                                   (64'd1 << FLAG_IF_BIT) |
                                                   (64'd1 << FLAG_RF_BIT) |
                                                   (64'd1 << FLAG_AC_BIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_flags <= '0;
      new_sp    <= '0;
    end else begin
      done <= fin_entry || fin_ret;
      if (fin_entry) begin
        new_cs    <= rdata;
        new_ip    <= ofs_q;
        new_flags <= flags_q & ~CLR_MASK;
        new_sp    <= sp_n;
      end else if (fin_ret) begin
        new_cs    <= rdata;
        new_ip    <= ofs_q;
        new_flags <= {flags_q[FLAG_W-1:DW], popfl_q};
        new_sp    <= sp_n;
      end
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int VEC_W  = 8,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              ret_req,
  input  logic [AW-1:0]     tbl_base,
  input  logic [DW-1:0]     cur_cs,
  input  logic [DW-1:0]     cur_ip,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic [AW-1:0]     cur_sp,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     new_cs,
  output logic [DW-1:0]     new_ip,
  output logic [FLAG_W-1:0] new_flags,
  output logic [AW-1:0]     new_sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rdy
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  seq_state_t        state_q, state_n;
  logic              busy_q, entry_kind_q;
  logic [AW-1:0]     sp_q, sp_n, base_q, base_n;
  logic [VEC_W-1:0]  vec_q, vec_n;
  logic [DW-1:0]     cs_q, cs_n, ip_q, ip_n, ofs_q, popfl_q;
  logic [FLAG_W-1:0] flags_q, flags_n;
  logic              step, accept_vec, accept_ret, accept;
  logic              fin_entry, fin_ret;
  logic [AW-1:0]     gen_addr;
  logic              gen_we, gen_active;
  logic [DW-1:0]     gen_wdata;

  assign step       = mem_req && mem_rdy;
  assign accept_vec = !busy_q && vec_valid;
  assign accept_ret = !busy_q && !vec_valid && ret_req;
  assign accept     = accept_vec || accept_ret;
  assign fin_entry  = step && (state_q == ST_RD_SEL);
  assign fin_ret    = step && (state_q == ST_POP_CS);
  assign busy       = busy_q;

  // next state
  always_comb begin
    state_n = state_q;
    if (state_q == ST_IDLE) begin
      if (accept_vec)      state_n = ST_PUSH_CS;
      else if (accept_ret) state_n = ST_POP_FL;
    end else if (step) begin
      unique case (state_q)
        ST_PUSH_CS: state_n = ST_PUSH_IP;
        ST_PUSH_IP: state_n = ST_PUSH_FL;
        ST_PUSH_FL: state_n = ST_RD_OFS;
        ST_RD_OFS:  state_n = ST_RD_SEL;
        ST_RD_SEL:  state_n = ST_IDLE;
        ST_POP_FL:  state_n = ST_POP_IP;
        ST_POP_IP:  state_n = ST_POP_CS;
        ST_POP_CS:  state_n = ST_IDLE;
        default:    state_n = ST_IDLE;
      endcase
    end
  end

  // working stack pointer and captured context
  always_comb begin
    if (accept)                         sp_n = cur_sp;
    else if (step && is_push(state_q))  sp_n = sp_q - STEP;
    else if (step && is_pop(state_q))   sp_n = sp_q + STEP;
    else                                sp_n = sp_q;
    cs_n    = accept ? cur_cs    : cs_q;
    ip_n    = accept ? cur_ip    : ip_q;
    flags_n = accept ? cur_flags : flags_q;
    vec_n   = accept ? vec_num   : vec_q;
    base_n  = accept ? tbl_base  : base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      busy_q       <= 1'b0;
      entry_kind_q <= 1'b0;
      sp_q         <= '0;
      cs_q         <= '0;
      ip_q         <= '0;
      flags_q      <= '0;
      vec_q        <= '0;
      base_q       <= '0;
      ofs_q        <= '0;
      popfl_q      <= '0;
    end else begin
      state_q <= state_n;
      sp_q    <= sp_n;
      cs_q    <= cs_n;
      ip_q    <= ip_n;
      flags_q <= flags_n;
      vec_q   <= vec_n;
      base_q  <= base_n;
      if (accept) begin
        busy_q       <= 1'b1;
        entry_kind_q <= accept_vec;
      end else if (fin_entry || fin_ret) begin
        busy_q <= 1'b0;
      end
      if (step && (state_q == ST_RD_OFS || state_q == ST_POP_IP))
        ofs_q <= mem_rdata;
      if (step && state_q == ST_POP_FL)
        popfl_q <= mem_rdata;
    end
  end

  int_seq_addr_gen #(.AW(AW), .DW(DW), .VEC_W(VEC_W)) addr_gen_i (
    .state_n (state_n),
    .sp_n    (sp_n),
    .base_n  (base_n),
    .vec_n   (vec_n),
    .cs_n    (cs_n),
    .ip_n    (ip_n),
    .fl_n    (flags_n[DW-1:0]),
    .addr    (gen_addr),
    .we      (gen_we),
    .wdata   (gen_wdata),
    .active  (gen_active)
  );

  int_seq_mem_port #(.AW(AW), .DW(DW)) mem_port_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept || step),
    .active    (gen_active),
    .addr      (gen_addr),
    .we        (gen_we),
    .wdata     (gen_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  int_seq_result #(.AW(AW), .DW(DW), .FLAG_W(FLAG_W)) result_i (
    .clk       (clk),
    .rst       (rst),
    .fin_entry (fin_entry),
    .fin_ret   (fin_ret),
    .rdata     (mem_rdata),
    .ofs_q     (ofs_q),
    .popfl_q   (popfl_q),
    .flags_q   (flags_q),
    .sp_n      (sp_n),
    .done      (done),
    .new_cs    (new_cs),
    .new_ip    (new_ip),
    .new_flags (new_flags),
    .new_sp    (new_sp)
  );

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mem_req);

  // R9: a pending request holds its fields until ready
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R8: while busy the sequence advances only on a completed access
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !step) |=> $stable(state_q));

  // R7: results are announced only once busy has dropped
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy_q);

  // R4: entry results never carry the cleared flags
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    (done && entry_kind_q) |-> (!new_flags[FLAG_IF_BIT] && !new_flags[FLAG_TF_BIT] &&
                                !new_flags[FLAG_RF_BIT] && !new_flags[FLAG_AC_BIT]));
endmodule

// File: tb/int_entry_seq_tb.sv
module int_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vec_valid = 1'b0;
  logic [7:0]  vec_num = '0;
  logic        ret_req = 1'b0;
  logic [15:0] tbl_base = '0;
  logic [15:0] cur_cs = '0, cur_ip = '0, cur_sp = '0;
  logic [31:0] cur_flags = '0;
  logic        busy, done, mem_req, mem_we, mem_rdy;
  logic [15:0] new_cs, new_ip, new_sp, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] new_flags;

  logic [15:0] mem [0:1023];
  logic [3:0]  wait_cfg = '0;
  logic [3:0]  wcnt;
  int          n_tests = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_entry_seq dut_i (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_num(vec_num),
    .ret_req(ret_req), .tbl_base(tbl_base), .cur_cs(cur_cs), .cur_ip(cur_ip),
    .cur_flags(cur_flags), .cur_sp(cur_sp), .busy(busy), .done(done),
    .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags), .new_sp(new_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  // memory model with programmable wait states
  assign mem_rdy   = mem_req && (wcnt == wait_cfg);
  assign mem_rdata = mem[mem_addr[10:1]];
  always @(posedge clk) begin
    if (rst || !mem_req || mem_rdy) wcnt <= '0;
    else                            wcnt <= wcnt + 4'd1;
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[10:1]] <= mem_wdata;
  end

  function automatic logic [15:0] ent_ofs(input int i);
    return 16'h4000 + 16'(i) * 16'h0103;
  endfunction
  function automatic logic [15:0] ent_sel(input int i);
    return 16'h2000 ^ (16'(i) << 4) ^ 16'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic do_entry(input int v, input logic [15:0] base, input logic [15:0] cs,
                          input logic [15:0] ip, input logic [31:0] fl,
                          input logic [15:0] sp, input int w, input bit with_ret,
                          input bit poke);
    int n = 0;
    bit got = 0;
    int idx;
    int dones = 0;
    logic [31:0] fexp;
    wait_cfg = 4'(w);
    vec_valid = 1'b1; vec_num = 8'(v); ret_req = with_ret; tbl_base = base;
    cur_cs = cs; cur_ip = ip; cur_flags = fl; cur_sp = sp;
    while (n < 200 && !got) begin
      @(negedge clk);
      n++;
      if (n == 1) begin vec_valid = 1'b0; ret_req = 1'b0; end
      if (poke && n == 2) begin vec_valid = 1'b1; vec_num = 8'(v + 1); ret_req = 1'b1; end
      if (poke && n == 3) begin vec_valid = 1'b0; ret_req = 1'b0; end
      if (done) got = 1;
    end
    idx  = int'(16'(base + 16'(v) * 16'd4) >> 2);
    fexp = fl & ~32'h0005_0300;
    chk("R9 entry latency", n, 5 * (w + 1) + 1);
    chk("R7 busy low with done", busy, 0);
    chk("R2 R5 new_ip from table", new_ip, ent_ofs(idx));
    chk("R2 R5 new_cs from table", new_cs, ent_sel(idx));
    chk("R4 entry flags", new_flags, fexp);
    chk("R5 new_sp", new_sp, 16'(sp - 16'd6));
    chk("R3 cs at sp-2", mem[10'((sp - 16'd2) >> 1)], cs);
    chk("R3 ip at sp-4", mem[10'((sp - 16'd4) >> 1)], ip);
    chk("R3 flags at sp-6", mem[10'((sp - 16'd6) >> 1)], fl[15:0]);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) dones++;
      if (k == 0) chk("R7 done one cycle", done, 0);
    end
    chk("R8 no extra sequence", dones, 0);
  endtask

  task automatic do_ret(input logic [15:0] sp, input logic [15:0] upper, input int w,
                        input logic [15:0] ecs, input logic [15:0] eip,
                        input logic [15:0] efl);
    int n = 0;
    bit got = 0;
    wait_cfg = 4'(w);
    ret_req = 1'b1; cur_sp = sp; cur_flags = {upper, 16'h5A5A};
    while (n < 200 && !got) begin
      @(negedge clk);
      n++;
      if (n == 1) ret_req = 1'b0;
      if (done) got = 1;
    end
    chk("R9 return latency", n, 3 * (w + 1) + 1);
    chk("R6 restored ip", new_ip, eip);
    chk("R6 restored cs", new_cs, ecs);
    chk("R6 restored flags", new_flags, {upper, efl});
    chk("R6 new_sp", new_sp, 16'(sp + 16'd6));
    @(negedge clk);
    chk("R7 done one cycle after return", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 256; i++) begin
      mem[2*i]   = ent_ofs(i);
      mem[2*i+1] = ent_sel(i);
    end
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep every vector, then return from each frame
    for (int v = 0; v < 256; v++) begin
      logic [15:0] cs, ip, sp;
      logic [31:0] fl;
      cs = 16'h1000 + 16'(v);
      ip = 16'hA000 ^ (16'(v) * 16'd7);
      fl = {13'h0, 3'(v), 8'(v) ^ 8'h5A, 8'(v)};
      sp = 16'h07F0 - 16'(v % 8) * 16'd16;
      do_entry(v, 16'h0000, cs, ip, fl, sp, v % 3, 0, 0);
      do_ret(16'(sp - 16'd6), 16'hBEEF ^ 16'(v), (v + 1) % 3, cs, ip, fl[15:0]);
    end

    // R2: table address wraps: 0xFFF0 + 5*4 lands on entry 1
    do_entry(5, 16'hFFF0, 16'h1234, 16'h5678, 32'hFFFF_FFFF, 16'h0700, 1, 0, 0);
    // R8: stray vector and return while busy are ignored
    do_entry(40, 16'h0000, 16'h0BAD, 16'hCAFE, 32'h0004_0200, 16'h0680, 2, 0, 1);
    // R10: simultaneous vector and return while idle performs the entry
    do_entry(77, 16'h0000, 16'h7777, 16'h1111, 32'h0001_0100, 16'h0660, 0, 1, 0);

    finish_run();
  end
endmodule